// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block holds the interrupt presentation state of a single processor. Source controllers offer it interrupts, each as a source number and a priority. The block keeps at most one pending interrupt and raises an interrupt line to the CPU while one is pending. Lower priority numbers are more favoured. A pending source is handed back to the source side as a reject when it is displaced by a more favoured request or by an inter-processor interrupt (IPI). The block also forwards end-of-interrupt notices to the source side and asks the sources to resend.

The processor reaches the block through a one-cycle operation port. The operations are accept, poll, end-of-interrupt, set the current priority, and set the IPI request priority. The presentation word and the IPI request priority are always visible on read ports. A request that arrives in the same cycle as an operation is evaluated against the state that the operation leaves behind.

Top module: `intr_presenter`

## Requirements
- R1: The presentation word `pres_word` holds the current priority in bits 31:24 and the pending source number in bits 23:0. After reset `pres_word` is 0, `ipi_prio` is 0xFF, the internal pending priority is 0xFF, and `irq_out`, `rej_valid`, `eoi_valid` and `resend_req` are low.
- R2: A request with `req_src` nonzero and priority P becomes pending on the next edge only if P is below the current priority and no pending source has a pending priority less than or equal to P. A request with `req_src` equal to 0 is ignored.
- R3: When a pending source that came from a request is displaced, `rej_valid` pulses for one cycle with `rej_src` equal to that number, one cycle after the operation or request. A pending IPI (source number 2) is never rejected.
- R4: `irq_out` is high exactly while the pending source number is nonzero.
- R5: Accept (`op_code` 1) returns the current `pres_word` in its cycle. On the next edge the current priority becomes the old pending priority, the source number becomes 0, the pending priority becomes 0xFF, and `irq_out` drops.
- R6: Poll (`op_code` 2) changes no state. The read ports give the presentation word and the IPI request priority.
- R7: Setting the IPI priority (`op_code` 5, value in `op_wdata[7:0]`) stores the value. Only when the value is below the current priority does it run the IPI check. The IPI check presents source 2 with the IPI priority unless a source is pending with pending priority less than or equal to it.
- R8: Setting the current priority (`op_code` 4, value in `op_wdata[7:0]`) stores the value. When the value is below the old priority and also less than or equal to the pending priority, the pending source is cleared, rejected if it came from a request, and the pending priority becomes 0xFF. Any lowering is followed by the resend sequence.
- R9: End-of-interrupt (`op_code` 3) loads `op_wdata[31:24]` as the current priority. One cycle later it pulses `eoi_valid` with `eoi_src` = `op_wdata[23:0]`. It then runs the resend sequence.
- R10: The resend sequence runs the IPI check when the IPI priority is below the new current priority, and pulses `resend_req` for one cycle on the next edge.
- R11: A request in the same cycle as an operation is evaluated after the effect of that operation, including any IPI check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | 0 idle, 1 accept, 2 poll, 3 EOI, 4 set priority, 5 set IPI priority |
| op_wdata | input | 32 | Operand for EOI and the set operations |
| pres_word | output | 32 | Current priority and pending source number |
| ipi_prio | output | 8 | IPI request priority |
| req_valid | input | 1 | Presentation request strobe |
| req_src | input | 24 | Requested source number |
| req_prio | input | 8 | Requested priority |
| irq_out | output | 1 | Interrupt line to the CPU |
| rej_valid | output | 1 | Reject pulse |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_src | output | 24 | Source being ended |
| resend_req | output | 1 | Resend request to all sources |

## Verification
The assertions check the following on every cycle:
- the interrupt line tracks the pending number;
- an accept clears the pending source;
- a poll leaves the state alone;
- requests at or above the current priority are dropped;
- an IPI is never rejected;
- every reject names the source that was pending;
- each EOI produces its pulse and a resend.

Only the bench scenarios can show the full sequences, where a reference model has to follow the pending priority:
- a displacement by priority;
- an IPI that yields to a more favoured pending source;
- a priority drop that clears a pending source;
- an operation and a request in the same cycle.

// File: rtl/intr_presenter.sv
module intr_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              op_code,
  input  logic [PRIO_W+SRC_W-1:0] op_wdata,
  output logic [PRIO_W+SRC_W-1:0] pres_word,
  output logic [PRIO_W-1:0]       ipi_prio,
  input  logic                    req_valid,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [PRIO_W-1:0]       req_prio,
  output logic                    irq_out,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_req
);
  localparam logic [2:0] OP_ACCEPT = 3'd1;
  localparam logic [2:0] OP_EOI    = 3'd3;
  localparam logic [2:0] OP_CPPR   = 3'd4;
  localparam logic [2:0] OP_IPI    = 3'd5;
  localparam logic [PRIO_W-1:0] LEAST = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] cur, pend, mfrr;
  logic [SRC_W-1:0]  src;
  logic              owned;

  logic [PRIO_W-1:0] n_cur, n_pend, n_mfrr;
  logic [SRC_W-1:0]  n_src, n_rej_src, n_eoi_src;
  logic              n_owned, n_rej, n_eoi, n_resend, do_ipi;
  logic [PRIO_W-1:0] wprio;

  assign wprio     = op_wdata[PRIO_W-1:0];
  assign pres_word = {cur, src};
  assign ipi_prio  = mfrr;
  assign irq_out   = |src;

  always_comb begin
    n_cur = cur; n_pend = pend; n_mfrr = mfrr; n_src = src; n_owned = owned;
    n_rej = 1'b0; n_rej_src = '0; n_eoi = 1'b0; n_eoi_src = '0;
    n_resend = 1'b0; do_ipi = 1'b0;
    case (op_code)
      OP_ACCEPT: begin
        n_cur = pend; n_src = '0; n_pend = LEAST; n_owned = 1'b0;
      end
      OP_EOI: begin
        n_cur     = op_wdata[PRIO_W+SRC_W-1:SRC_W];
        n_eoi     = 1'b1;
        n_eoi_src = op_wdata[SRC_W-1:0];
        n_resend  = 1'b1;
        do_ipi    = mfrr < op_wdata[PRIO_W+SRC_W-1:SRC_W];
      end
      OP_CPPR: begin
        n_cur = wprio;
        if (wprio < cur) begin
          if ((src != '0) && (wprio <= pend)) begin
            if (owned) begin
              n_rej = 1'b1; n_rej_src = src;
            end
            n_src = '0; n_pend = LEAST; n_owned = 1'b0;
          end
          n_resend = 1'b1;
          do_ipi   = mfrr < wprio;
        end
      end
      OP_IPI: begin
        n_mfrr = wprio;
        do_ipi = wprio < cur;
      end
      default: ;
    endcase

    if (do_ipi && !((n_src != '0) && (n_pend <= n_mfrr))) begin
      if ((n_src != '0) && n_owned) begin
        n_rej = 1'b1; n_rej_src = n_src;
      end
      n_src = IPI_NUM; n_pend = n_mfrr; n_owned = 1'b0;
    end

    if (req_valid && (req_src != '0) && (req_prio < n_cur) &&
        !((n_src != '0) && (n_pend <= req_prio))) begin
      if ((n_src != '0) && n_owned) begin
        n_rej = 1'b1; n_rej_src = n_src;
      end
      n_src = req_src; n_pend = req_prio; n_owned = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0; src <= '0; pend <= LEAST; mfrr <= LEAST; owned <= 1'b0;
      rej_valid <= 1'b0; rej_src <= '0; eoi_valid <= 1'b0; eoi_src <= '0;
      resend_req <= 1'b0;
    end else begin
      cur <= n_cur; src <= n_src; pend <= n_pend; mfrr <= n_mfrr; owned <= n_owned;
      rej_valid <= n_rej; rej_src <= n_rej_src;
      eoi_valid <= n_eoi; eoi_src <= n_eoi_src;
      resend_req <= n_resend;
    end
  end
endmodule

// File: rtl/intr_presenter_chk.sv
module intr_presenter_chk #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2:0]              op_code,
  input logic [PRIO_W+SRC_W-1:0] op_wdata,
  input logic [PRIO_W+SRC_W-1:0] pres_word,
  input logic [PRIO_W-1:0]       ipi_prio,
  input logic                    req_valid,
  input logic [PRIO_W-1:0]       req_prio,
  input logic                    irq_out,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic                    resend_req
);
  a_r4_line_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (pres_word[SRC_W-1:0] != '0));

  a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd1 && !req_valid) |=> (pres_word[SRC_W-1:0] == '0) && !irq_out);

  a_r6_poll_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd2 && !req_valid) |=> $stable(pres_word) && $stable(ipi_prio));

  a_r2_drop_unfavoured: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd0 && req_valid && req_prio >= pres_word[PRIO_W+SRC_W-1:SRC_W])
      |=> $stable(pres_word));

  a_r3_reject_names_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rej_valid) |-> (rej_src == $past(pres_word[SRC_W-1:0])) && (rej_src != '0));

  a_r3_ipi_never_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> rej_src != SRC_W'(IPI_SRC));

  a_r9_eoi_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd3) |=> eoi_valid && resend_req && (eoi_src == $past(op_wdata[SRC_W-1:0])));

  a_r7_ipi_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd5 && !req_valid && op_wdata[PRIO_W-1:0] >= pres_word[PRIO_W+SRC_W-1:SRC_W])
      |=> $stable(pres_word[SRC_W-1:0]));
endmodule

bind intr_presenter intr_presenter_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_wdata(op_wdata),
  .pres_word(pres_word), .ipi_prio(ipi_prio), .req_valid(req_valid),
  .req_prio(req_prio), .irq_out(irq_out), .rej_valid(rej_valid),
  .rej_src(rej_src), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
  .resend_req(resend_req));

// File: tb/tb_intr_presenter.sv
module tb_intr_presenter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] op_wdata = '0;
  logic [31:0] pres_word;
  logic [7:0]  ipi_prio;
  logic        req_valid = 1'b0;
  logic [23:0] req_src = '0;
  logic [7:0]  req_prio = '0;
  logic        irq_out, rej_valid, eoi_valid, resend_req;
  logic [23:0] rej_src, eoi_src;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  intr_presenter dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_wdata(op_wdata),
    .pres_word(pres_word), .ipi_prio(ipi_prio), .req_valid(req_valid),
    .req_src(req_src), .req_prio(req_prio), .irq_out(irq_out),
    .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid),
    .eoi_src(eoi_src), .resend_req(resend_req));

  logic [7:0]  m_cur, m_pend, m_mfrr;
  logic [23:0] m_src;
  logic        m_own;
  logic        e_rej, e_eoi, e_resend;
  logic [23:0] e_rej_src, e_eoi_src;
  string       tag;

  function automatic bit blocked(input logic [23:0] s, input logic [7:0] pp, input logic [7:0] p);
    return (s != 0) && (pp <= p);
  endfunction

  task automatic model(input logic [2:0] op, input logic [31:0] w,
                       input logic rv, input logic [23:0] rs, input logic [7:0] rp);
    bit ipi = 0;
    e_rej = 0; e_rej_src = 0; e_eoi = 0; e_eoi_src = 0; e_resend = 0;
    case (op)
      3'd1: begin tag = "R5"; m_cur = m_pend; m_src = 0; m_pend = 8'hFF; m_own = 0; end
      3'd2: tag = "R6";
      3'd3: begin
        tag = "R9"; m_cur = w[31:24]; e_eoi = 1; e_eoi_src = w[23:0]; e_resend = 1;
        ipi = m_mfrr < m_cur;
      end
      3'd4: begin
        tag = "R8";
        if (w[7:0] < m_cur) begin
          if (m_src != 0 && w[7:0] <= m_pend) begin
            if (m_own) begin e_rej = 1; e_rej_src = m_src; end
            m_src = 0; m_pend = 8'hFF; m_own = 0;
          end
          e_resend = 1; ipi = m_mfrr < w[7:0];
        end
        m_cur = w[7:0];
      end
      3'd5: begin tag = "R7"; m_mfrr = w[7:0]; ipi = w[7:0] < m_cur; end
      default: tag = "R2";
    endcase
    if (op != 0 && rv) tag = "R11";
    if (ipi && !blocked(m_src, m_pend, m_mfrr)) begin
      if (m_src != 0 && m_own) begin e_rej = 1; e_rej_src = m_src; end
      m_src = 24'd2; m_pend = m_mfrr; m_own = 0;
    end
    if (rv && rs != 0 && rp < m_cur && !blocked(m_src, m_pend, rp)) begin
      if (m_src != 0 && m_own) begin e_rej = 1; e_rej_src = m_src; end
      m_src = rs; m_pend = rp; m_own = 1;
    end
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(tag, "pres_word", pres_word, {m_cur, m_src});
    check("R6", "ipi_prio", {24'd0, ipi_prio}, {24'd0, m_mfrr});
    check("R4", "irq_out", {31'd0, irq_out}, {31'd0, (m_src != 0)});
    check("R3", "rej_valid", {31'd0, rej_valid}, {31'd0, e_rej});
    if (e_rej) check("R3", "rej_src", {8'd0, rej_src}, {8'd0, e_rej_src});
    check("R9", "eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi});
    if (e_eoi) check("R9", "eoi_src", {8'd0, eoi_src}, {8'd0, e_eoi_src});
    check("R10", "resend_req", {31'd0, resend_req}, {31'd0, e_resend});
  endtask

  task automatic step(input logic [2:0] op, input logic [31:0] w,
                      input logic rv, input logic [23:0] rs, input logic [7:0] rp);
    op_code = op; op_wdata = w; req_valid = rv; req_src = rs; req_prio = rp;
    model(op, w, rv, rs, rp);
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [7:0] pick_prio();
    int v = $urandom % 10;
    if (v < 8) return 8'(v);
    if (v == 8) return 8'hFF;
    return 8'($urandom);
  endfunction

  initial begin
    #1600000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_cur = 0; m_src = 0; m_pend = 8'hFF; m_mfrr = 8'hFF; m_own = 0;
    e_rej = 0; e_eoi = 0; e_resend = 0; e_rej_src = 0; e_eoi_src = 0; tag = "R1";
    compare_all();
    // R2: current priority 0 blocks everything
    step(3'd0, 0, 1, 24'd5, 8'd0);
    step(3'd4, 32'hFF, 0, 0, 0);
    // R2: presented, then displaced by a more favoured request (R3)
    step(3'd0, 0, 1, 24'd7, 8'd6);
    step(3'd0, 0, 1, 24'd9, 8'd6);
    step(3'd0, 0, 1, 24'd9, 8'd3);
    step(3'd0, 0, 1, 24'd0, 8'd1);
    // R7: IPI at priority 4 loses to pending priority 3, then wins at 1
    step(3'd5, 32'd4, 0, 0, 0);
    step(3'd5, 32'd1, 0, 0, 0);
    step(3'd0, 0, 1, 24'd11, 8'd2);
    // R5: accept, then R9 EOI back to FF with resend and IPI recheck
    step(3'd1, 0, 0, 0, 0);
    step(3'd2, 0, 0, 0, 0);
    step(3'd5, 32'hFF, 0, 0, 0);
    step(3'd3, 32'hFF00_0002, 0, 0, 0);
    // R8: lowering the priority clears and rejects a pending request
    step(3'd0, 0, 1, 24'd12, 8'd5);
    step(3'd4, 32'd5, 0, 0, 0);
    // R11: same-cycle accept and request
    step(3'd4, 32'hFF, 1, 24'd13, 8'd7);
    step(3'd1, 0, 1, 24'd14, 8'd6);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      logic [2:0] op;
      logic [31:0] w;
      case (r)
        0, 1:  op = 3'd1;
        2:     op = 3'd2;
        3, 4:  op = 3'd3;
        5, 6:  op = 3'd4;
        7:     op = 3'd5;
        default: op = 3'd0;
      endcase
      w = {(($urandom % 3) == 0) ? 8'hFF : pick_prio(), 24'($urandom % 12)};
      if (op == 3'd4 && ($urandom % 2) == 0) w[7:0] = 8'hFF;
      else if (op == 3'd4 || op == 3'd5) w[7:0] = pick_prio();
      step(op, w, ($urandom % 3) != 0, ($urandom % 8 == 0) ? 24'd0 : 24'(3 + $urandom % 20), pick_prio());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule